// File: doc/BRIEF.md
# QPSK Integrate-and-Threshold Demodulator

This block turns a digitized QPSK waveform back into its in-phase and quadrature bits. Each clock it takes one unsigned 8-bit sample and multiplies it by a locally supplied cosine value and a locally supplied sine value. It adds each product into its own running sum. The reference waveforms carry a DC offset, so all arithmetic is unsigned. A sum collects products only during a programmable window that opens after each decision. The window length is set between one carrier period and one code period.

A decision is taken when the code clock is first seen high after being low. Each sum is compared with its own 16-bit threshold. A large sum means bit 0, and a sum at or below the threshold means bit 1. The two bits come out together with a one-cycle valid pulse. Both sums then restart from zero. The bits for one code period therefore appear at the start of the following code period. Carrier generation, phase tracking and code despreading are handled elsewhere.

Top module: `qpsk_itd_demod`

## Requirements
- R1: The I sum accumulates sample*cos and the Q sum accumulates sample*sin as unsigned products. Each sum is 24 bits wide, enough for 255 full-scale products without wrapping.
- R2: After a decision, only the first win_len clock cycles add into the sums. Samples after the window closes are ignored. win_len = 0 adds nothing.
- R3: A decision is taken at the first clock edge where chip_clk is sampled high after having been sampled low. Its results are visible right after that edge. Holding chip_clk high gives no further decisions.
- R4: A sum strictly greater than its threshold decodes as 0. A sum less than or equal to its threshold decodes as 1.
- R5: The I decision uses only thr_i and the Q decision uses only thr_q.
- R6: At a decision both sums and the window count restart from zero. The sample present in the decision cycle is not added.
- R7: bit_vld is high for exactly one cycle per decision. bit_i and bit_q hold their values until the next decision.
- R8: While rst is high at a clock edge, the sums, the window count, bit_i, bit_q and bit_vld are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp | input | 8 | Unsigned input sample |
| ref_cos | input | 8 | Local cosine value with DC offset |
| ref_sin | input | 8 | Local sine value with DC offset |
| chip_clk | input | 1 | Code clock level; its rising edge triggers a decision |
| thr_i | input | 16 | Decision threshold for the I sum |
| thr_q | input | 16 | Decision threshold for the Q sum |
| win_len | input | 8 | Accumulation window length in clock cycles |
| bit_i | output | 1 | Recovered in-phase bit |
| bit_q | output | 1 | Recovered quadrature bit |
| bit_vld | output | 1 | One-cycle strobe marking a new decision |

## Verification
A decision result is due on the first clock edge at which chip_clk is high after being low. The bench raises chip_clk on a falling edge and reads bit_i, bit_q and bit_vld on the next falling edge. It reads bit_vld once more one cycle later to confirm it has dropped.

The sums seen at that decision count every rising edge after the previous decision, up to win_len of them. Most tests hold the inputs steady for far longer than the window, so each expected sum is simply win_len*smp*ref. The window, early-decision and reset tests instead change or stop the inputs at counted falling edges, so exactly the intended number of products is added.

// File: rtl/qpsk_itd_demod.sv
module qpsk_itd_demod #(
  parameter int SW = 8,
  parameter int TW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] smp,
  input  logic [SW-1:0] ref_cos,
  input  logic [SW-1:0] ref_sin,
  input  logic          chip_clk,
  input  logic [TW-1:0] thr_i,
  input  logic [TW-1:0] thr_q,
  input  logic [LW-1:0] win_len,
  output logic          bit_i,
  output logic          bit_q,
  output logic          bit_vld
);
  localparam int PW = 2 * SW;
  localparam int AW = PW + LW;

  logic          chip_q;
  logic [LW-1:0] cnt;
  logic [AW-1:0] acc_i, acc_q;
  logic [PW-1:0] prod_i, prod_q;

  assign prod_i = PW'(smp) * PW'(ref_cos);
  assign prod_q = PW'(smp) * PW'(ref_sin);

  wire decide = chip_clk & ~chip_q;
  wire open_w = cnt < win_len;
  wire [AW-1:0] thr_i_w = {{(AW-TW){1'b0}}, thr_i};
  wire [AW-1:0] thr_q_w = {{(AW-TW){1'b0}}, thr_q};

  always_ff @(posedge clk) chip_q <= chip_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_i   <= '0;
      acc_q   <= '0;
      cnt     <= '0;
      bit_i   <= 1'b0;
      bit_q   <= 1'b0;
      bit_vld <= 1'b0;
    end else if (decide) begin
      bit_i   <= !(acc_i > thr_i_w);
      bit_q   <= !(acc_q > thr_q_w);
      bit_vld <= 1'b1;
      acc_i   <= '0;
      acc_q   <= '0;
      cnt     <= '0;
    end else begin
      bit_vld <= 1'b0;
      if (open_w) begin
        acc_i <= acc_i + AW'(prod_i);
        acc_q <= acc_q + AW'(prod_q);
        cnt   <= cnt + 1'b1;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);

  a_r3_edge_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (chip_clk && !$past(chip_clk)) |-> ##1 bit_vld);

  a_r3_no_edge_no_valid: assert property (@(posedge clk) disable iff (rst)
    !(chip_clk && !$past(chip_clk)) |=> !bit_vld);

  a_r6_clear_on_decide: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> (acc_i == '0 && acc_q == '0 && cnt == '0));

  a_r2_hold_after_window: assert property (@(posedge clk) disable iff (rst)
    (!decide && !open_w) |=> ($stable(acc_i) && $stable(acc_q)));

  a_r1_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!decide && open_w) |=> (acc_i >= $past(acc_i) && acc_q >= $past(acc_q)));
endmodule

// File: tb/tb_qpsk_itd_demod.sv
module tb_qpsk_itd_demod;
  logic clk = 1'b0, rst = 1'b1, chip = 1'b0;
  logic [7:0] smp = '0, rc = '0, rs = '0, len = '0;
  logic [15:0] ti = '0, tq = '0;
  logic bi, bq, bv;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  qpsk_itd_demod dut (.clk(clk), .rst(rst), .smp(smp), .ref_cos(rc), .ref_sin(rs),
    .chip_clk(chip), .thr_i(ti), .thr_q(tq), .win_len(len),
    .bit_i(bi), .bit_q(bq), .bit_vld(bv));

  typedef struct packed {
    logic [7:0] s, c, q, l;
    logic [15:0] ti, tq;
    logic ei, eq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd200, 8'd200, 8'd50,  8'd1,   16'd20000, 16'd20000, 1'b0, 1'b1},
    '{8'd10,  8'd10,  8'd10,  8'd10,  16'd999,   16'd1000,  1'b0, 1'b1},
    '{8'd0,   8'd90,  8'd90,  8'd20,  16'd0,     16'd0,     1'b1, 1'b1},
    '{8'd255, 8'd255, 8'd255, 8'd255, 16'hFFFF,  16'hFFFF,  1'b0, 1'b0},
    '{8'd100, 8'd3,   8'd7,   8'd50,  16'd20000, 16'd20000, 1'b1, 1'b0},
    '{8'd255, 8'd255, 8'd255, 8'd0,   16'd0,     16'd0,     1'b1, 1'b1},
    '{8'd128, 8'd128, 8'd0,   8'd2,   16'd32767, 16'd0,     1'b0, 1'b1},
    '{8'd1,   8'd1,   8'd1,   8'd255, 16'd254,   16'd255,   1'b0, 1'b1}
  };

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // raise chip_clk; on return outputs of the decision are visible
  task automatic decide_now();
    @(negedge clk) chip = 1'b1;
    @(negedge clk) chip = 1'b0;
  endtask

  task automatic set_in(logic [7:0] s, c, q, l, logic [15:0] a, b);
    smp = s; rc = c; rs = q; len = l; ti = a; tq = b;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R8 reset bit_i", bi, 0);
    check("R8 reset bit_q", bq, 0);
    check("R8 reset bit_vld", bv, 0);
    rst = 1'b0;

    foreach (VEC[k]) begin
      set_in(VEC[k].s, VEC[k].c, VEC[k].q, VEC[k].l, VEC[k].ti, VEC[k].tq);
      decide_now();
      repeat (300) @(negedge clk);
      decide_now();
      check($sformatf("R1 R4 R5 vec%0d bit_i", k), bi, VEC[k].ei);
      check($sformatf("R1 R4 R5 vec%0d bit_q", k), bq, VEC[k].eq);
      check($sformatf("R3 vec%0d bit_vld", k), bv, 1);
      @(negedge clk);
      check($sformatf("R7 vec%0d vld drop", k), bv, 0);
      check($sformatf("R7 vec%0d bit_i hold", k), bi, VEC[k].ei);
    end

    // R2: samples after the window closes are ignored (sum stays 200)
    set_in(8'd10, 8'd10, 8'd10, 8'd2, 16'd199, 16'd200);
    decide_now();
    repeat (2) @(negedge clk);
    smp = 8'd255;
    repeat (50) @(negedge clk);
    decide_now();
    check("R2 window I", bi, 0);
    check("R2 window Q", bq, 1);

    // R6: decision before window ends, only one product added (sum 1)
    set_in(8'd1, 8'd1, 8'd1, 8'd10, 16'd0, 16'd1);
    decide_now();
    decide_now();
    check("R6 early decide I", bi, 0);
    check("R6 early decide Q", bq, 1);

    // R3: chip_clk held high gives one decision only
    @(negedge clk) chip = 1'b1;
    @(negedge clk);
    check("R3 held high first vld", bv, 1);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check("R3 held high no repeat", bv, 0);
    end
    chip = 1'b0;

    // R8: reset mid-accumulation clears sums and outputs
    set_in(8'd255, 8'd255, 8'd255, 8'd255, 16'd0, 16'd0);
    decide_now();
    repeat (20) @(negedge clk);
    smp = 8'd0; rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset bit_i", bi, 0);
    check("R8 mid reset bit_vld", bv, 0);
    rst = 1'b0;
    decide_now();
    check("R8 sums cleared I", bi, 1);
    check("R8 sums cleared Q", bq, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule